// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Tagged Receive Queue and Automatic Flow Control

This block turns an asynchronous serial line into characters. A strobe at sixteen times the bit rate, produced by a baud generator outside the block, times the sampling. A high-to-low transition starts a character. The receiver checks the line again halfway through the start bit and drops the event if the line has gone high by then. It then recovers five to eight data bits, least significant bit first, plus an optional parity bit and one stop bit.

Each character goes into a receive queue together with three tags: parity error, framing error and line break. The queue holds sixteen entries in queued mode and a single entry in holding-register mode. The head entry and its tags are always visible at the read port, and a one-cycle read strobe removes the head entry. A character that completes while the queue is full is discarded and raises a sticky overrun flag.

When automatic flow control is enabled, the ready-to-receive output drops once the queue fills to a selectable level. This tells the far transmitter to pause. The output rises again once reads bring the occupancy back below that level.

Top module: `uart_rx_autorts`

## Requirements
- R1: The line is sampled only on `tick16` cycles, once per bit in the middle of the bit, 16 strobes apart. A character starts when the synchronised line reads low on a strobe. Data bits arrive least significant first.
- R2: If the line reads high on the 8th strobe after start detection, the event is a false start. No entry is stored, and the receiver goes back to looking for a start bit.
- R3: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits of `rd_data` above the character length read 0.
- R4: `parity_sel` selects the parity check: 0 or 3 means no parity bit, 1 means odd and 2 means even. `rd_parity_err` is 1 when the received parity bit does not match.
- R5: A character whose stop bit samples low, and that is not a break, is stored with `rd_frame_err`=1 and `rd_break`=0. A stop bit that samples high gives `rd_frame_err`=0.
- R6: A break is a character in which every sample reads low: start, data, parity and stop. It stores exactly one entry with data 0x00, `rd_break`=1, `rd_frame_err`=1 and `rd_parity_err`=0. No further entry is stored until the line has gone high again.
- R7: The queue holds 16 entries when `fifo_en`=1 and 1 entry when `fifo_en`=0, and keeps arrival order. `rx_ready` is 1 while at least one entry is stored. The read port shows the head entry and its tags, and `rd_en` removes that entry.
- R8: A character that completes while the queue is full, with no read in the same cycle, is discarded. The stored entries are not changed, and `overrun` is set. `overrun` stays at 1 until a cycle in which `rd_en` removes an entry.
- R9: If a character completes in the same cycle as a read on a full queue, the head is removed, the new character is stored and `overrun` stays 0.
- R10: With `auto_rts_en`=1, `rts` is 0 while occupancy is at or above the threshold and 1 below it. `rts_trig_sel` values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 entries in queued mode, and the threshold is 1 in holding-register mode. With `auto_rts_en`=0, `rts` stays at 1.
- R11: After reset the queue is empty, `rx_ready`=0, `overrun`=0, `rts`=1, and the receiver is looking for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, asynchronous, idles high |
| len_sel | input | 2 | Data bit count: 5 + value |
| parity_sel | input | 2 | 0/3 none, 1 odd, 2 even |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding entry |
| auto_rts_en | input | 1 | Enables automatic flow control on `rts` |
| rts_trig_sel | input | 2 | Threshold select: 1, 4, 8, 14 entries |
| rd_en | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head entry data |
| rd_parity_err | output | 1 | Head entry parity error tag |
| rd_frame_err | output | 1 | Head entry framing error tag |
| rd_break | output | 1 | Head entry break tag |
| rx_ready | output | 1 | At least one entry is stored |
| overrun | output | 1 | Sticky: a character was discarded |
| rts | output | 1 | Ready-to-receive, 1 = far end may send |

## Verification
A character can complete in the same cycle as a read strobe while the queue is full, so a push and a pop land on the same edge. To provoke this, the bench first sends a calibration character on an empty holding register, starting at a fixed phase of its strobe divider. It measures how many cycles pass before `rx_ready` rises. It then sends a second character from the same phase with the register full, and raises `rd_en` for exactly the edge on which that character completes. The result is judged at the ports: the new character must be at the head, `rx_ready` must stay high and `overrun` must stay low.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    localparam int unsigned FIFO_DEPTH = 16;
    localparam int unsigned OSR        = 16;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_ODD      = 2'd1,
        PAR_EVEN     = 2'd2,
        PAR_NONE_ALT = 2'd3
    } parity_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       frame_err;
        logic       parity_err;
        logic [7:0] data;
    } rx_entry_t;

    // index of the last data bit for a length select (5..8 bits -> 4..7)
    function automatic logic [2:0] last_bit_index(input logic [1:0] sel);
        return {1'b1, sel};
    endfunction

    function automatic logic parity_enabled(input parity_e mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN);
    endfunction

    // value the parity bit must carry for the given data
    function automatic logic parity_bit(input parity_e mode, input logic [7:0] data);
        return (mode == PAR_ODD) ? ~(^data) : (^data);
    endfunction

    function automatic int unsigned trig_entries(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RESET_VAL}};
        else     sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
`timescale 1ns/1ps
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = OSR
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] len_sel,
    input  parity_e    par_mode,
    output logic       done,
    output rx_entry_t  entry
);
    localparam int unsigned    CW        = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0]  MID_TICK  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0]  LAST_TICK = CW'(OVERSAMPLE - 1);

    rx_state_e     state;
    logic [CW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          all_low;
    logic          par_bad;
    logic [2:0]    last_idx;
    logic          par_on;
    logic          at_last;
    logic          is_break;

    assign last_idx = last_bit_index(len_sel);
    assign par_on   = parity_enabled(par_mode);
    assign at_last  = (tcnt == LAST_TICK);
    assign is_break = all_low & ~rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            all_low <= 1'b0;
            par_bad <= 1'b0;
            done    <= 1'b0;
            entry   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_HUNT: begin
                        if (!rx) begin
                            state <= ST_START;
                            tcnt  <= '0;
                        end
                    end
                    ST_START: begin
                        if (tcnt == MID_TICK) begin
                            tcnt <= '0;
                            if (rx) begin
                                state <= ST_HUNT;          // false start (R2)
                            end else begin
                                state   <= ST_DATA;
                                bidx    <= '0;
                                shreg   <= '0;
                                all_low <= 1'b1;
                                par_bad <= 1'b0;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_last) begin
                            tcnt        <= '0;
                            shreg[bidx] <= rx;
                            all_low     <= all_low & ~rx;
                            if (bidx == last_idx) state <= par_on ? ST_PARITY : ST_STOP;
                            else                  bidx  <= bidx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        if (at_last) begin
                            tcnt    <= '0;
                            par_bad <= (rx != parity_bit(par_mode, shreg));
                            all_low <= all_low & ~rx;
                            state   <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_last) begin
                            tcnt             <= '0;
                            done             <= 1'b1;
                            entry.brk        <= is_break;
                            entry.frame_err  <= ~rx;
                            entry.parity_err <= par_bad & ~is_break;
                            entry.data       <= is_break ? 8'h00 : shreg;
                            state            <= rx ? ST_HUNT : ST_WAIT_HIGH;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_WAIT_HIGH: begin
                        if (rx) state <= ST_HUNT;
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_mode,
    input  logic          push_valid,
    input  rx_entry_t     push_entry,
    input  logic          pop,
    output rx_entry_t     head,
    output logic [LW-1:0] level,
    output logic          overrun
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [LW-1:0] cap;
    logic          full;
    logic          do_pop;
    logic          do_push;
    logic          drop;

    assign cap     = fifo_mode ? LW'(DEPTH) : LW'(1);
    assign full    = (level >= cap);
    assign do_pop  = pop && (level != '0);
    assign do_push = push_valid && (!full || do_pop);
    assign drop    = push_valid && full && !do_pop;
    assign head    = mem[rptr];

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wptr <= ptr_next(wptr);
            if (do_pop)  rptr <= ptr_next(rptr);
            level <= level + LW'(do_push) - LW'(do_pop);
            if (drop)        overrun <= 1'b1;
            else if (do_pop) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_rts.sv
`timescale 1ns/1ps
module uart_rx_rts
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          auto_en,
    input  logic          fifo_mode,
    input  logic [1:0]    trig_sel,
    input  logic [LW-1:0] level,
    output logic          rts
);
    logic [LW-1:0] thr;

    always_comb begin
        if (!fifo_mode) begin
            thr = LW'(1);
        end else if (trig_entries(trig_sel) > DEPTH) begin
            thr = LW'(DEPTH);
        end else begin
            thr = LW'(trig_entries(trig_sel));
        end
    end

    assign rts = !auto_en || (level < thr);
endmodule

// File: rtl/uart_rx_autorts.sv
`timescale 1ns/1ps
module uart_rx_autorts
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH       = FIFO_DEPTH,
    parameter int unsigned OVERSAMPLE  = OSR,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic [1:0] parity_sel,
    input  logic       fifo_en,
    input  logic       auto_rts_en,
    input  logic [1:0] rts_trig_sel,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_parity_err,
    output logic       rd_frame_err,
    output logic       rd_break,
    output logic       rx_ready,
    output logic       overrun,
    output logic       rts
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic          rx_s;
    logic          char_done;
    rx_entry_t     char_entry;
    rx_entry_t     head;
    logic [LW-1:0] fifo_level;

    uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .rx       (rx_s),
        .len_sel  (len_sel),
        .par_mode (parity_e'(parity_sel)),
        .done     (char_done),
        .entry    (char_entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .LW(LW)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .fifo_mode  (fifo_en),
        .push_valid (char_done),
        .push_entry (char_entry),
        .pop        (rd_en),
        .head       (head),
        .level      (fifo_level),
        .overrun    (overrun)
    );

    uart_rx_rts #(.DEPTH(DEPTH), .LW(LW)) u_rts (
        .auto_en   (auto_rts_en),
        .fifo_mode (fifo_en),
        .trig_sel  (rts_trig_sel),
        .level     (fifo_level),
        .rts       (rts)
    );

    assign rd_data       = head.data;
    assign rd_parity_err = head.parity_err;
    assign rd_frame_err  = head.frame_err;
    assign rd_break      = head.brk;
    assign rx_ready      = (fifo_level != '0);
endmodule

// File: rtl/uart_rx_autorts_chk.sv
`timescale 1ns/1ps
module uart_rx_autorts_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic          auto_rts_en,
    input logic [1:0]    rts_trig_sel,
    input logic          rd_en,
    input logic          rx_ready,
    input logic          overrun,
    input logic          rts,
    input logic [LW-1:0] level
);
    localparam logic [LW-1:0] ONE = LW'(1);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH)); // R7

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && $past(!fifo_en) && $past(level) <= ONE) |-> (level <= ONE)); // R7

    AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rd_en) |=> rx_ready); // R7

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (level == $past(level)) || (level == $past(level) + ONE) || (level + ONE == $past(level))); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !rd_en) |=> overrun); // R8

    AST_OVR_NOT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> !$past(rd_en)); // R9

    AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (rst)
        !auto_rts_en |-> rts); // R10

    generate
        if (DEPTH >= 14) begin : g_top_trig
            AST_RTS_TOP: assert property (@(posedge clk) disable iff (rst)
                (auto_rts_en && fifo_en && rts_trig_sel == 2'd3 && level >= LW'(14)) |-> !rts); // R10
        end
    endgenerate
endmodule

bind uart_rx_autorts uart_rx_autorts_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fifo_en      (fifo_en),
    .auto_rts_en  (auto_rts_en),
    .rts_trig_sel (rts_trig_sel),
    .rd_en        (rd_en),
    .rx_ready     (rx_ready),
    .overrun      (overrun),
    .rts          (rts),
    .level        (fifo_level)
);

// File: tb/uart_rx_autorts_bench.sv
`timescale 1ns/1ps
module uart_rx_autorts_bench;
    localparam int DIV    = 4;
    localparam int BITCLK = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic       rxd = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic [1:0] parity_sel = 2'd0;
    logic       fifo_en = 1'b1;
    logic       auto_rts_en = 1'b0;
    logic [1:0] rts_trig_sel = 2'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_parity_err, rd_frame_err, rd_break;
    logic       rx_ready, overrun, rts;

    int checks = 0;
    int failures = 0;
    int tdiv = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (tdiv == DIV - 1) tdiv <= 0;
        else                 tdiv <= tdiv + 1;
    end
    assign tick16 = (tdiv == DIV - 1);

    uart_rx_autorts u_uart_rx_autorts (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .len_sel(len_sel), .parity_sel(parity_sel), .fifo_en(fifo_en),
        .auto_rts_en(auto_rts_en), .rts_trig_sel(rts_trig_sel), .rd_en(rd_en),
        .rd_data(rd_data), .rd_parity_err(rd_parity_err), .rd_frame_err(rd_frame_err),
        .rd_break(rd_break), .rx_ready(rx_ready), .overrun(overrun), .rts(rts)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b);
        rxd = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    // pmode: 0 none, 1 odd, 2 even
    task automatic send_frame(input logic [7:0] d, input int nbits, input int pmode,
                              input logic bad_par, input logic stop);
        logic [7:0] m;
        logic p;
        m = d & 8'((1 << nbits) - 1);
        hold_bit(1'b0);
        for (int i = 0; i < nbits; i++) hold_bit(m[i]);
        if (pmode == 1 || pmode == 2) begin
            p = (pmode == 2) ? ^m : ~(^m);
            hold_bit(p ^ bad_par);
        end
        hold_bit(stop);
        hold_bit(1'b1);
    endtask

    task automatic pop_check(input string req, input logic [7:0] ed, input logic epe,
                             input logic efe, input logic ebrk);
        check(req, "rx_ready", rx_ready, 1);
        check(req, "rd_data", rd_data, ed);
        check(req, "parity_err", rd_parity_err, epe);
        check(req, "frame_err", rd_frame_err, efe);
        check(req, "break", rd_break, ebrk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pop_only();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic align();
        while (tdiv != 0) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11", "rx_ready after reset", rx_ready, 0);
        check("R11", "overrun after reset", overrun, 0);
        check("R11", "rts after reset", rts, 1);
        auto_rts_en = 1'b1;
        @(negedge clk);
        check("R11", "rts auto, empty", rts, 1);
        auto_rts_en = 1'b0;
    endtask

    task automatic t_basic();
        len_sel = 2'd3; parity_sel = 2'd0;
        send_frame(8'hA5, 8, 0, 0, 1);
        pop_check("R1", 8'hA5, 0, 0, 0);
        send_frame(8'h01, 8, 0, 0, 1);
        pop_check("R1", 8'h01, 0, 0, 0);
        check("R7", "empty after pop", rx_ready, 0);
    endtask

    task automatic t_lengths_parity();
        len_sel = 2'd2; parity_sel = 2'd2;
        send_frame(8'h55, 7, 2, 0, 1);
        pop_check("R4", 8'h55, 0, 0, 0);
        len_sel = 2'd0; parity_sel = 2'd1;
        send_frame(8'h1B, 5, 1, 1, 1);
        pop_check("R4", 8'h1B, 1, 0, 0);
        send_frame(8'hFF, 5, 1, 0, 1);
        pop_check("R3", 8'h1F, 0, 0, 0);
        len_sel = 2'd1; parity_sel = 2'd3;
        send_frame(8'hEA, 6, 0, 0, 1);
        pop_check("R3", 8'h2A, 0, 0, 0);
        len_sel = 2'd3; parity_sel = 2'd2;
        send_frame(8'hC3, 8, 2, 1, 1);
        pop_check("R4", 8'hC3, 1, 0, 0);
        parity_sel = 2'd0;
    endtask

    task automatic t_framing();
        send_frame(8'h81, 8, 0, 0, 0);
        pop_check("R5", 8'h81, 0, 1, 0);
    endtask

    task automatic t_break();
        rxd = 1'b0;
        repeat (BITCLK * 24) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK * 2) @(negedge clk);
        pop_check("R6", 8'h00, 0, 1, 1);
        check("R6", "single break entry", rx_ready, 0);
    endtask

    task automatic t_false_start();
        rxd = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK * 12) @(negedge clk);
        check("R2", "no entry from glitch", rx_ready, 0);
        send_frame(8'h3C, 8, 0, 0, 1);
        pop_check("R2", 8'h3C, 0, 0, 0);
    endtask

    task automatic t_fifo_overrun();
        fifo_en = 1'b1;
        for (int i = 0; i < 16; i++) send_frame(8'(i * 13 + 5), 8, 0, 0, 1);
        check("R8", "no overrun at 16", overrun, 0);
        send_frame(8'hEE, 8, 0, 0, 1);
        check("R8", "overrun on 17th", overrun, 1);
        for (int i = 0; i < 16; i++) begin
            pop_check("R7", 8'(i * 13 + 5), 0, 0, 0);
            if (i == 0) check("R8", "overrun cleared by read", overrun, 0);
        end
        check("R7", "empty after 16 reads", rx_ready, 0);
    endtask

    task automatic t_holding();
        fifo_en = 1'b0;
        send_frame(8'h11, 8, 0, 0, 1);
        send_frame(8'h22, 8, 0, 0, 1);
        check("R8", "holding overrun", overrun, 1);
        pop_check("R7", 8'h11, 0, 0, 0);
        check("R7", "holding single entry", rx_ready, 0);
        check("R8", "overrun cleared", overrun, 0);
    endtask

    task automatic t_same_cycle();
        int lat;
        fifo_en = 1'b0;
        align();
        lat = 0;
        fork
            send_frame(8'h33, 8, 0, 0, 1);
            begin
                do begin
                    @(negedge clk);
                    lat++;
                end while (!rx_ready);
            end
        join
        align();
        fork
            send_frame(8'h44, 8, 0, 0, 1);
            begin
                repeat (lat - 1) @(negedge clk);
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
            end
        join
        check("R9", "overrun on coincident read", overrun, 0);
        pop_check("R9", 8'h44, 0, 0, 0);
        check("R9", "empty afterwards", rx_ready, 0);
        fifo_en = 1'b1;
    endtask

    task automatic t_rts();
        fifo_en = 1'b1; auto_rts_en = 1'b1; rts_trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) send_frame(8'(8'h40 + i), 8, 0, 0, 1);
        check("R10", "rts below 4", rts, 1);
        send_frame(8'h43, 8, 0, 0, 1);
        check("R10", "rts at 4", rts, 0);
        pop_only();
        check("R10", "rts back below 4", rts, 1);
        for (int i = 0; i < 3; i++) pop_only();
        rts_trig_sel = 2'd3;
        for (int i = 0; i < 13; i++) send_frame(8'(8'h60 + i), 8, 0, 0, 1);
        check("R10", "rts at 13 of 14", rts, 1);
        send_frame(8'h6D, 8, 0, 0, 1);
        check("R10", "rts at 14", rts, 0);
        auto_rts_en = 1'b0;
        @(negedge clk);
        check("R10", "rts with auto off", rts, 1);
        for (int i = 0; i < 14; i++) pop_check("R10", 8'(8'h60 + i), 0, 0, 0);
        fifo_en = 1'b0; auto_rts_en = 1'b1;
        @(negedge clk);
        check("R10", "holding rts empty", rts, 1);
        send_frame(8'h77, 8, 0, 0, 1);
        check("R10", "holding rts full", rts, 0);
        pop_check("R10", 8'h77, 0, 0, 0);
        auto_rts_en = 1'b0; fifo_en = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lengths_parity();
        t_framing();
        t_break();
        t_false_start();
        t_fifo_overrun();
        t_holding();
        t_same_cycle();
        t_rts();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule